// File: doc/BRIEF.md
# Coprocessor Command Mailbox

This block is a two-direction, one-word mailbox between a host processor and a security coprocessor. The host sees a small register window: an outbound register that carries words toward the coprocessor and an inbound register that carries words back. Delivery and receipt are signalled in the data value itself. The outbound register reads back the pending word until the coprocessor takes it, and zero after that. The inbound register reads zero when nothing is waiting. The host releases an inbound word by writing the same value back to it. No status bits are involved.

The coprocessor side has a valid/ready pop port for outbound words and a push port for inbound words. The push port accepts a word only while the inbound slot is empty. A level interrupt tells the host that an inbound word is waiting. The block also decodes command words as they are accepted. It flags command words that carry bits in their reserved-zero fields. It also spots the two-write sequences that program the base addresses of two shared buffers: an address word followed by a buffer command.

Top module: `cpx_mailbox`

## Requirements
- R1: After a synchronous reset, both offsets read 0, `cpOutValid` and `hostIrq` are 0, `cpInReady` is 1, and both buffer bases and all three error bits are 0.
- R2: A host write to offset 0x10 while the outbound slot is empty stores the word. From the next cycle, offset 0x10 reads that word and `cpOutValid` is 1, with `cpOutData` equal to the word bit for bit (flag bits 20:18 included).
- R3: A cycle with `cpOutValid` and `cpOutReady` both high consumes the outbound word. From the next cycle, offset 0x10 reads 0 and `cpOutValid` is 0.
- R4: A host write to offset 0x10 while a word is pending (judged on the state before the edge, even if a pop happens in the same cycle) is dropped: the pending word is unchanged and `errOverrun` is set and stays set until reset.
- R5: While the inbound slot is empty, `cpInReady` is 1 and a `cpInPush` stores `cpInData`. From the next cycle, offset 0x00 reads that word and `hostIrq` is 1.
- R6: A `cpInPush` while the inbound slot is full is ignored, and the stored inbound word is unchanged.
- R7: A host write to offset 0x00 whose value equals the pending inbound word empties the slot. From the next cycle, offset 0x00 reads 0, `hostIrq` is 0 and `cpInReady` is 1.
- R8: A host write to offset 0x00 that differs from the pending inbound word is ignored: the slot stays full and `errMismatch` is set and stays set until reset. A write to offset 0x00 while the slot is empty has no effect.
- R9: An accepted outbound word with bit 0 set is a command. If any of its bits 7:1 or 17:13 is nonzero, `errMalformed` is set and stays set until reset. The word is still delivered unchanged.
- R10: An accepted outbound word with bit 0 clear is an address word. If the next accepted outbound word is a command whose ID (bits 12:8) is 0x00, `bufBase256` takes the address word's value in the cycle after that command is written.
- R11: In the same two-write sequence, a command with ID 0x09 loads `bufBase128` instead.
- R12: A command not directly preceded by an address word leaves both bases unchanged. A command with any other ID uses up the pending address without loading a base. A dropped write takes no part in the sequence.
- R13: Host writes to offsets other than 0x00 and 0x10 change nothing, and reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 8 | Host byte offset |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Read data for `hostAddr`, combinational |
| hostIrq | output | 1 | High while an inbound word waits |
| cpOutValid | output | 1 | Outbound word available to the coprocessor |
| cpOutReady | input | 1 | Coprocessor takes the outbound word |
| cpOutData | output | 32 | Outbound word |
| cpInPush | input | 1 | Coprocessor pushes an inbound word |
| cpInData | input | 32 | Inbound word |
| cpInReady | output | 1 | Inbound slot empty |
| bufBase256 | output | 32 | Recorded base of the 256-byte buffer |
| bufBase128 | output | 32 | Recorded base of the 128-byte buffer |
| errOverrun | output | 1 | Sticky: outbound write dropped |
| errMismatch | output | 1 | Sticky: inbound echo differed |
| errMalformed | output | 1 | Sticky: reserved command bits set |

## Verification
Every state change lands on the clock edge that samples the stimulus, and the read port is combinational from that state. So each effect (slot fill or drain, base load, error bit) is visible one cycle after its inputs are driven. The bench drives a cycle's inputs just after an edge and lets the next edge register them. One time step later it clears the write and handshake inputs and steps `hostAddr` through both offsets to sample reads and flags. It compares these against a model that advances once per edge from the state before that edge. That is the same ordering the requirements use for a same-cycle pop and write.

// File: rtl/cpx_mbox_pkg.sv
package cpx_mbox_pkg;
  localparam int WORD_W    = 32;
  localparam int VALID_BIT = 0;
  localparam int ID_LSB    = 8;
  localparam int ID_W      = 5;
  // reserved-zero fields of a command: bits 7:1 and 17:13
  localparam logic [WORD_W-1:0] RSVD_MASK =
    ((WORD_W'(1) << 8) - WORD_W'(2)) | (((WORD_W'(1) << 18) - 1) & ~((WORD_W'(1) << 13) - 1));

  typedef struct packed {
    logic outLoad;
    logic outClear;
    logic inLoad;
    logic inClear;
    logic addrLatch;
    logic base256Load;
    logic base128Load;
  } mboxStrobes_t;
endpackage

// File: rtl/cpx_mbox_ctrl.sv
module cpx_mbox_ctrl
  import cpx_mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OUT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] IN_OFS = 8'h00,
  parameter logic [ID_W-1:0] BUF256_ID = 5'h00,
  parameter logic [ID_W-1:0] BUF128_ID = 5'h09
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic              cpOutReady,
  input  logic              cpInPush,
  input  logic              echoMatch,
  output mboxStrobes_t      strobes,
  output logic              outFull,
  output logic              inFull,
  output logic              errOverrun,
  output logic              errMismatch,
  output logic              errMalformed
);
  logic wrOut, wrIn, isCmd, rsvdBad, outAccept, pop, pushAcc, ackOk, ackBad;
  logic addrPend;
  logic [ID_W-1:0] cmdId;

  always_comb begin
    wrOut     = hostWrEn && (hostAddr == OUT_OFS);
    wrIn      = hostWrEn && (hostAddr == IN_OFS);
    isCmd     = hostWrData[VALID_BIT];
    cmdId     = hostWrData[ID_LSB +: ID_W];
    rsvdBad   = |(hostWrData & RSVD_MASK);
    outAccept = wrOut && !outFull;
    pop       = outFull && cpOutReady;
    pushAcc   = cpInPush && !inFull;
    ackOk     = wrIn && inFull && echoMatch;
    ackBad    = wrIn && inFull && !echoMatch;
  end

  always_comb begin
    strobes             = '0;
    strobes.outLoad     = outAccept;
    strobes.outClear    = pop;
    strobes.inLoad      = pushAcc;
    strobes.inClear     = ackOk;
    strobes.addrLatch   = outAccept && !isCmd;
    strobes.base256Load = outAccept && isCmd && addrPend && (cmdId == BUF256_ID);
    strobes.base128Load = outAccept && isCmd && addrPend && (cmdId == BUF128_ID);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outFull      <= 1'b0;
      inFull       <= 1'b0;
      addrPend     <= 1'b0;
      errOverrun   <= 1'b0;
      errMismatch  <= 1'b0;
      errMalformed <= 1'b0;
    end else begin
      if (outAccept)   outFull <= 1'b1;
      else if (pop)    outFull <= 1'b0;
      if (pushAcc)     inFull <= 1'b1;
      else if (ackOk)  inFull <= 1'b0;
      if (outAccept)   addrPend <= !isCmd;
      if (wrOut && outFull) errOverrun <= 1'b1;
      if (ackBad)      errMismatch <= 1'b1;
      if (outAccept && isCmd && rsvdBad) errMalformed <= 1'b1;
    end
  end

  a_r4_overrun_flag: assert property (@(posedge clk) disable iff (rst)
    (wrOut && outFull) |=> errOverrun);
  a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    errOverrun |=> errOverrun);
  a_r3_pop_empties: assert property (@(posedge clk) disable iff (rst)
    (outFull && cpOutReady) |=> !outFull);
  a_r8_mismatch_keeps_full: assert property (@(posedge clk) disable iff (rst)
    ackBad |=> (inFull && errMismatch));
  a_r6_full_push_keeps_full: assert property (@(posedge clk) disable iff (rst)
    (inFull && cpInPush && !wrIn) |=> inFull);
  a_r9_malformed_flag: assert property (@(posedge clk) disable iff (rst)
    (outAccept && isCmd && rsvdBad) |=> errMalformed);
  a_r12_single_base: assert property (@(posedge clk) disable iff (rst)
    $countones({strobes.base256Load, strobes.base128Load, strobes.addrLatch}) <= 1);
endmodule

// File: rtl/cpx_mbox_dp.sv
module cpx_mbox_dp
  import cpx_mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OUT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] IN_OFS = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  mboxStrobes_t      strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic [WORD_W-1:0] cpInData,
  input  logic              outFull,
  input  logic              inFull,
  output logic [WORD_W-1:0] outWord,
  output logic [WORD_W-1:0] hostRdData,
  output logic              echoMatch,
  output logic [WORD_W-1:0] bufBase256,
  output logic [WORD_W-1:0] bufBase128
);
  logic [WORD_W-1:0] inWord, addrHold;

  always_ff @(posedge clk) begin
    if (rst) begin
      outWord    <= '0;
      inWord     <= '0;
      addrHold   <= '0;
      bufBase256 <= '0;
      bufBase128 <= '0;
    end else begin
      if (strobes.outLoad)     outWord    <= hostWrData;
      if (strobes.inLoad)      inWord     <= cpInData;
      if (strobes.addrLatch)   addrHold   <= hostWrData;
      if (strobes.base256Load) bufBase256 <= addrHold;
      if (strobes.base128Load) bufBase128 <= addrHold;
    end
  end

  always_comb begin
    echoMatch = (hostWrData == inWord);
    if (hostAddr == OUT_OFS)     hostRdData = outFull ? outWord : '0;
    else if (hostAddr == IN_OFS) hostRdData = inFull ? inWord : '0;
    else                         hostRdData = '0;
  end

  a_r4_out_word_held: assert property (@(posedge clk) disable iff (rst)
    (outFull && !strobes.outLoad) |=> $stable(outWord));
  a_r5_in_capture: assert property (@(posedge clk) disable iff (rst)
    strobes.inLoad |=> (inWord == $past(cpInData)));
  a_r6_in_word_held: assert property (@(posedge clk) disable iff (rst)
    inFull |=> $stable(inWord));
  a_r10_base256_source: assert property (@(posedge clk) disable iff (rst)
    strobes.base256Load |=> (bufBase256 == $past(addrHold)));
  a_r11_base128_source: assert property (@(posedge clk) disable iff (rst)
    strobes.base128Load |=> (bufBase128 == $past(addrHold)));
endmodule

// File: rtl/cpx_mailbox.sv
module cpx_mailbox
  import cpx_mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OUT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] IN_OFS = 8'h00,
  parameter logic [ID_W-1:0] BUF256_ID = 5'h00,
  parameter logic [ID_W-1:0] BUF128_ID = 5'h09
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  output logic              hostIrq,
  output logic              cpOutValid,
  input  logic              cpOutReady,
  output logic [WORD_W-1:0] cpOutData,
  input  logic              cpInPush,
  input  logic [WORD_W-1:0] cpInData,
  output logic              cpInReady,
  output logic [WORD_W-1:0] bufBase256,
  output logic [WORD_W-1:0] bufBase128,
  output logic              errOverrun,
  output logic              errMismatch,
  output logic              errMalformed
);
  mboxStrobes_t strobes;
  logic outFull, inFull, echoMatch;

  cpx_mbox_ctrl #(.ADDR_W(ADDR_W), .OUT_OFS(OUT_OFS), .IN_OFS(IN_OFS),
                  .BUF256_ID(BUF256_ID), .BUF128_ID(BUF128_ID)) u_ctrl (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .cpOutReady(cpOutReady), .cpInPush(cpInPush),
    .echoMatch(echoMatch), .strobes(strobes), .outFull(outFull), .inFull(inFull),
    .errOverrun(errOverrun), .errMismatch(errMismatch), .errMalformed(errMalformed)
  );

  cpx_mbox_dp #(.ADDR_W(ADDR_W), .OUT_OFS(OUT_OFS), .IN_OFS(IN_OFS)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .cpInData(cpInData), .outFull(outFull), .inFull(inFull),
    .outWord(cpOutData), .hostRdData(hostRdData), .echoMatch(echoMatch),
    .bufBase256(bufBase256), .bufBase128(bufBase128)
  );

  assign cpOutValid = outFull;
  assign cpInReady  = !inFull;
  assign hostIrq    = inFull;

  a_r5_irq_tracks_ready: assert property (@(posedge clk) disable iff (rst)
    hostIrq != cpInReady);
endmodule

// File: tb/tb_cpx_mailbox.sv
`timescale 1ns/100ps
module tb_cpx_mailbox;
  logic clk = 1'b0;
  logic rst;
  logic hostWrEn, cpOutReady, cpInPush;
  logic [7:0] hostAddr;
  logic [31:0] hostWrData, cpInData, hostRdData, cpOutData, bufBase256, bufBase128;
  logic hostIrq, cpOutValid, cpInReady, errOverrun, errMismatch, errMalformed;

  int nTests = 0;
  int nFail = 0;

  // bench model
  bit mOutFull, mInFull, mAddrPend, mErrOv, mErrMm, mErrMal;
  bit [31:0] mOutWord, mInWord, mAddrHold, mB256, mB128;

  always #2 clk = ~clk;

  cpx_mailbox dut (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostIrq(hostIrq),
    .cpOutValid(cpOutValid), .cpOutReady(cpOutReady), .cpOutData(cpOutData),
    .cpInPush(cpInPush), .cpInData(cpInData), .cpInReady(cpInReady),
    .bufBase256(bufBase256), .bufBase128(bufBase128), .errOverrun(errOverrun),
    .errMismatch(errMismatch), .errMalformed(errMalformed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] mkCmd(input bit [4:0] id, input bit [2:0] flg);
    return {11'd0, flg, 5'd0, id, 7'd0, 1'b1};
  endfunction

  function automatic bit rsvdSet(input bit [31:0] w);
    return (w[7:1] != 7'd0) || (w[17:13] != 5'd0);
  endfunction

  task automatic modelReset();
    mOutFull = 0; mInFull = 0; mAddrPend = 0; mErrOv = 0; mErrMm = 0; mErrMal = 0;
    mOutWord = 0; mInWord = 0; mAddrHold = 0; mB256 = 0; mB128 = 0;
  endtask

  task automatic modelStep(input bit we, input bit [7:0] a, input bit [31:0] d,
                           input bit rdy, input bit push, input bit [31:0] pd);
    bit wrOut, wrIn, outAcc, pop, pushAcc, ack;
    wrOut   = we && a == 8'h10;
    wrIn    = we && a == 8'h00;
    outAcc  = wrOut && !mOutFull;
    pop     = mOutFull && rdy;
    pushAcc = push && !mInFull;
    ack     = wrIn && mInFull && d == mInWord;
    if (wrOut && mOutFull) mErrOv = 1;
    if (wrIn && mInFull && d != mInWord) mErrMm = 1;
    if (outAcc) begin
      mOutWord = d;
      if (d[0]) begin
        if (rsvdSet(d)) mErrMal = 1;
        if (mAddrPend && d[12:8] == 5'h00) mB256 = mAddrHold;
        if (mAddrPend && d[12:8] == 5'h09) mB128 = mAddrHold;
        mAddrPend = 0;
      end else begin
        mAddrPend = 1;
        mAddrHold = d;
      end
    end
    if (outAcc) mOutFull = 1;
    else if (pop) mOutFull = 0;
    if (pushAcc) begin mInFull = 1; mInWord = pd; end
    else if (ack) mInFull = 0;
  endtask

  // Compare every port against the model; tags name the requirements involved.
  task automatic checkAll(input string tag);
    hostWrEn = 0; cpOutReady = 0; cpInPush = 0;
    hostAddr = 8'h10; #0.2;
    check({tag, " R2 R3 R4 read 0x10"}, hostRdData, mOutFull ? mOutWord : 32'h0);
    check({tag, " R2 R3 cpOutValid"}, {31'd0, cpOutValid}, {31'd0, mOutFull});
    if (mOutFull) check({tag, " R2 cpOutData"}, cpOutData, mOutWord);
    hostAddr = 8'h00; #0.2;
    check({tag, " R5 R7 R8 read 0x00"}, hostRdData, mInFull ? mInWord : 32'h0);
    check({tag, " R5 R7 hostIrq"}, {31'd0, hostIrq}, {31'd0, mInFull});
    check({tag, " R5 R7 cpInReady"}, {31'd0, cpInReady}, {31'd0, !mInFull});
    hostAddr = 8'h14; #0.2;
    check({tag, " R13 read other"}, hostRdData, 32'h0);
    check({tag, " R10 R12 base256"}, bufBase256, mB256);
    check({tag, " R11 R12 base128"}, bufBase128, mB128);
    check({tag, " R4 errOverrun"}, {31'd0, errOverrun}, {31'd0, mErrOv});
    check({tag, " R8 errMismatch"}, {31'd0, errMismatch}, {31'd0, mErrMm});
    check({tag, " R9 errMalformed"}, {31'd0, errMalformed}, {31'd0, mErrMal});
  endtask

  task automatic cyc(input string tag, input bit we, input bit [7:0] a, input bit [31:0] d,
                     input bit rdy, input bit push, input bit [31:0] pd);
    hostWrEn = we; hostAddr = a; hostWrData = d;
    cpOutReady = rdy; cpInPush = push; cpInData = pd;
    @(posedge clk);
    modelStep(we, a, d, rdy, push, pd);
    #1;
    checkAll(tag);
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    hostWrEn = 0; hostAddr = 0; hostWrData = 0; cpOutReady = 0; cpInPush = 0; cpInData = 0;
    process::self().srandom(32'd20240611);
    rst = 1;
    repeat (3) @(posedge clk);
    modelReset();
    #1;
    rst = 0;
    checkAll("R1 reset");

    // R2 and R3: deliver, then pop
    cyc("R2 write", 1, 8'h10, mkCmd(5'h03, 3'b101), 0, 0, 0);
    cyc("R2 hold", 0, 8'h10, 0, 0, 0, 0);
    cyc("R3 pop", 0, 8'h10, 0, 1, 0, 0);
    // R4: overrun with a same-cycle pop
    cyc("R4 fill", 1, 8'h10, 32'h1234_5600, 0, 0, 0);
    cyc("R4 overrun+pop", 1, 8'h10, 32'hDEAD_0000, 1, 0, 0);
    // R10: address then ID 0 command
    cyc("R10 addr", 1, 8'h10, 32'h4030_0000, 0, 0, 0);
    cyc("R10 pop", 0, 8'h10, 0, 1, 0, 0);
    cyc("R10 cmd", 1, 8'h10, mkCmd(5'h00, 3'b000), 1, 0, 0);
    cyc("R10 pop", 0, 8'h10, 0, 1, 0, 0);
    // R11: address then ID 9 command, malformed bits (R9)
    cyc("R11 addr", 1, 8'h10, 32'h1F84_0000, 0, 0, 0);
    cyc("R11 pop", 0, 8'h10, 0, 1, 0, 0);
    cyc("R11 R9 cmd", 1, 8'h10, mkCmd(5'h09, 3'b010) | 32'h0000_2000, 1, 0, 0);
    // R12: command without a preceding address
    cyc("R12 cmd", 1, 8'h10, mkCmd(5'h00, 3'b111), 1, 0, 0);
    cyc("R12 pop", 0, 8'h10, 0, 1, 0, 0);
    // R5, R6, R8, R7: inbound path
    cyc("R8 echo empty", 1, 8'h00, 32'h0000_0055, 0, 0, 0);
    cyc("R5 push", 0, 8'h00, 0, 0, 1, 32'hCAFE_F00D);
    cyc("R6 push full", 0, 8'h00, 0, 0, 1, 32'h0BAD_0BAD);
    cyc("R8 mismatch", 1, 8'h00, 32'hCAFE_F00C, 0, 0, 0);
    cyc("R7 echo", 1, 8'h00, 32'hCAFE_F00D, 0, 0, 0);
    // R13: other offset write
    cyc("R13 other", 1, 8'h14, 32'hFFFF_FFFF, 0, 0, 0);

    // Reset again, then random mix
    rst = 1; @(posedge clk); modelReset(); #1; rst = 0;
    checkAll("R1 reset2");
    for (int i = 0; i < 1500; i++) begin
      bit we, rdy, push;
      bit [7:0] a;
      bit [31:0] d, pd;
      int sel;
      sel  = $urandom_range(0, 9);
      we   = $urandom_range(0, 2) != 0;
      rdy  = $urandom_range(0, 2) == 0;
      push = $urandom_range(0, 3) == 0;
      pd   = $urandom | 32'h1;
      if (sel < 5) begin
        a = 8'h10;
        case ($urandom_range(0, 3))
          0: d = $urandom & 32'hFFFF_FFF0;
          1: d = mkCmd(5'h00, 3'($urandom));
          2: d = mkCmd(5'h09, 3'($urandom));
          default: d = mkCmd(5'($urandom), 3'($urandom)) |
                       (($urandom_range(0, 3) == 0) ? 32'h0000_4002 : 32'h0);
        endcase
      end else if (sel < 8) begin
        a = 8'h00;
        d = ($urandom_range(0, 3) != 0) ? mInWord : $urandom;
      end else begin
        a = 8'h04 << $urandom_range(0, 3);
        d = $urandom;
      end
      cyc("rand", we, a, d, rdy, push, pd);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule